// File: doc/BRIEF.md
# CAN Controller Interrupt Status and Clear Logic

This block holds the interrupt status of a CAN controller. The controller core gives it single-cycle event pulses (arbitration lost, transmit done, receive done, overflow, bus-off, sleep entry and exit), five error-source lines, FIFO level flags, and FIFO occupancy counts. It compares the counts against programmed watermarks. Each condition sets one bit of a 15-bit sticky status word. A bit stays set until software clears it.

Software reaches the block over a small register bus with three registers. The first is the status word, which is read-only. The second is an enable mask, which can be read and written. The third is a clear port: it stores nothing, writing 1s to it clears the matching status bits, and reading it returns zero. The single interrupt line is high whenever any set status bit also has its enable bit set.

A separate core-enable input affects only the event-type bits. While it is low, it wipes those bits. The level-type bits keep their value across a core disable.

There is no sequencing state in this block. Its only storage is the two registers. Each cycle, every status bit takes one of three transitions: hold, set or clear.

Top module: `can_irq_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the status word and the enable mask to zero, and `irq` is low afterwards.
- R2: Every status bit is sticky. After its condition is seen at a clock edge, the bit reads 1 from that edge on, until it is cleared, even when the condition has gone away.
- R3: Each event input sets its own status bit. The mapping is: `arb_lost_p` to bit 0, `tx_done_p` to bit 1, `tx_fifo_full` to bit 2, `tx_hp_full` to bit 3, `rx_done_p` to bit 4, `rx_ovf_p` to bit 6, a non-zero `rx_count` to bit 7, `bus_off_p` to bit 9, `sleep_in_p` to bit 10, `sleep_out_p` to bit 11, and `tx_fifo_empty` to bit 14.
- R4: Bit 8 sets when any one of the five `err_src` lines is high.
- R5: Bit 5 sets when `rx_pop` is high while `rx_count` is zero. A pop with a non-zero count does not set bit 5.
- R6: Bit 12 sets only when `rx_count` is strictly greater than `rx_wmark`. Bit 13 sets only when `tx_free` is strictly greater than `tx_wmark`. Equality sets neither bit.
- R7: The register addresses are: 0 for status, 1 for enable, 2 for clear. A write of 1 to a bit of the clear register (address 2) clears that status bit. A 0 bit in that write leaves its status bit unchanged. Reading address 2 returns zero.
- R8: When a set condition and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: While `core_en` is low, bits 0, 1, 4, 6, 8, 9, 10 and 11 are cleared and stay clear. Bits 2, 3, 5, 7, 12, 13 and 14 keep their value.
- R10: The enable mask at address 1 can be written and read back. `irq` is high exactly when some status bit and the same enable bit are both 1.
- R11: A write to the status address (0) changes neither the status word nor the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_en | input | 1 | Core enable; while low, event-type bits are cleared |
| arb_lost_p | input | 1 | Arbitration lost pulse |
| tx_done_p | input | 1 | Transmit complete pulse |
| rx_done_p | input | 1 | Receive complete pulse |
| rx_ovf_p | input | 1 | RX FIFO overflow pulse |
| bus_off_p | input | 1 | Bus-off entry pulse |
| sleep_in_p | input | 1 | Sleep entry pulse |
| sleep_out_p | input | 1 | Sleep exit pulse |
| err_src | input | 5 | Error-status sources |
| tx_fifo_full | input | 1 | TX FIFO full level |
| tx_hp_full | input | 1 | TX high-priority buffer full level |
| tx_fifo_empty | input | 1 | TX FIFO empty level |
| rx_pop | input | 1 | Software read strobe of the RX FIFO |
| rx_count | input | CNT_W | RX FIFO occupancy |
| rx_wmark | input | CNT_W | RX watermark |
| tx_free | input | CNT_W | TX FIFO free entries |
| tx_wmark | input | CNT_W | TX watermark |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 15 | Write data |
| bus_rdata | output | 15 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst` is high for at least one edge before any checked behaviour. They also assume that inputs change only away from the rising edge. The stimulus meets this by driving every input on the falling edge and holding reset through the first edges.

The assertions take each set condition as it appears at the edge. They do not assume that pulses last one cycle. The bench keeps event pulses to one cycle anyway, and it keeps `rx_count` zero and `rx_wmark` at its maximum unless a test needs otherwise, so that the count-derived bits 7 and 12 do not set by accident.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int unsigned NBITS = 15;
    localparam int unsigned AW    = 2;

    typedef logic [NBITS-1:0] irq_vec_t;

    typedef enum logic [AW-1:0] {
        ADDR_STAT = 2'd0,
        ADDR_ENAB = 2'd1,
        ADDR_CLR  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int unsigned B_ARB   = 0;
    localparam int unsigned B_TXD   = 1;
    localparam int unsigned B_TXF   = 2;
    localparam int unsigned B_HPF   = 3;
    localparam int unsigned B_RXD   = 4;
    localparam int unsigned B_UNF   = 5;
    localparam int unsigned B_OVF   = 6;
    localparam int unsigned B_RXNE  = 7;
    localparam int unsigned B_ERR   = 8;
    localparam int unsigned B_BOFF  = 9;
    localparam int unsigned B_SLPI  = 10;
    localparam int unsigned B_SLPO  = 11;
    localparam int unsigned B_RXWM  = 12;
    localparam int unsigned B_TXWM  = 13;
    localparam int unsigned B_TXE   = 14;

    // Bits wiped while the core is disabled
    localparam irq_vec_t CORE_CLR_MASK = irq_vec_t'((1 << B_ARB) | (1 << B_TXD) |
        (1 << B_RXD) | (1 << B_OVF) | (1 << B_ERR) | (1 << B_BOFF) |
        (1 << B_SLPI) | (1 << B_SLPO));
endpackage

// File: rtl/can_irq_setgen.sv
module can_irq_setgen
    import can_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned NERR  = 5
) (
    input  logic             arb_lost_p,
    input  logic             tx_done_p,
    input  logic             rx_done_p,
    input  logic             rx_ovf_p,
    input  logic             bus_off_p,
    input  logic             sleep_in_p,
    input  logic             sleep_out_p,
    input  logic [NERR-1:0]  err_src,
    input  logic             tx_fifo_full,
    input  logic             tx_hp_full,
    input  logic             tx_fifo_empty,
    input  logic             rx_pop,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_wmark,
    input  logic [CNT_W-1:0] tx_free,
    input  logic [CNT_W-1:0] tx_wmark,
    output irq_vec_t         set_vec
);
    logic rx_empty;
    assign rx_empty = (rx_count == '0);

    always_comb begin
        set_vec         = '0;
        set_vec[B_ARB]  = arb_lost_p;
        set_vec[B_TXD]  = tx_done_p;
        set_vec[B_TXF]  = tx_fifo_full;
        set_vec[B_HPF]  = tx_hp_full;
        set_vec[B_RXD]  = rx_done_p;
        set_vec[B_UNF]  = rx_pop && rx_empty;
        set_vec[B_OVF]  = rx_ovf_p;
        set_vec[B_RXNE] = !rx_empty;
        set_vec[B_ERR]  = |err_src;
        set_vec[B_BOFF] = bus_off_p;
        set_vec[B_SLPI] = sleep_in_p;
        set_vec[B_SLPO] = sleep_out_p;
        set_vec[B_RXWM] = rx_count > rx_wmark;
        set_vec[B_TXWM] = tx_free > tx_wmark;
        set_vec[B_TXE]  = tx_fifo_empty;
    end
endmodule

// File: rtl/can_irq_stat.sv
module can_irq_stat
    import can_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     core_en,
    input  irq_vec_t set_vec,
    input  irq_vec_t clr_vec,
    output irq_vec_t stat_q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic nxt;
        always_comb begin
            if (CORE_CLR_MASK[i] && !core_en) nxt = 1'b0;
            else                              nxt = set_vec[i] | (stat_q[i] & ~clr_vec[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) stat_q[i] <= 1'b0;
            else     stat_q[i] <= nxt;
        end

        // R2
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !clr_vec[i] && (core_en || !CORE_CLR_MASK[i])) |=> stat_q[i]);

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (set_vec[i] && (core_en || !CORE_CLR_MASK[i])) |=> stat_q[i]);
    end

    // R9
    core_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        !core_en |=> ((stat_q & CORE_CLR_MASK) == '0));
endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
    import can_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  irq_vec_t      bus_wdata,
    input  irq_vec_t      stat_q,
    output irq_vec_t      enab_q,
    output irq_vec_t      clr_vec,
    output irq_vec_t      bus_rdata
);
    reg_addr_e addr;
    logic      wr_en;

    assign addr  = reg_addr_e'(bus_addr);
    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst)                             enab_q <= '0;
        else if (wr_en && addr == ADDR_ENAB) enab_q <= bus_wdata;
    end

    assign clr_vec = (wr_en && addr == ADDR_CLR) ? bus_wdata : '0;

    always_comb begin
        unique case (addr)
            ADDR_STAT: bus_rdata = stat_q;
            ADDR_ENAB: bus_rdata = enab_q;
            ADDR_CLR:  bus_rdata = '0;
            ADDR_NONE: bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end

    // R11
    enab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_ENAB) |=> $stable(enab_q));
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_en,
    input  logic             arb_lost_p,
    input  logic             tx_done_p,
    input  logic             rx_done_p,
    input  logic             rx_ovf_p,
    input  logic             bus_off_p,
    input  logic             sleep_in_p,
    input  logic             sleep_out_p,
    input  logic [4:0]       err_src,
    input  logic             tx_fifo_full,
    input  logic             tx_hp_full,
    input  logic             tx_fifo_empty,
    input  logic             rx_pop,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_wmark,
    input  logic [CNT_W-1:0] tx_free,
    input  logic [CNT_W-1:0] tx_wmark,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [14:0]      bus_wdata,
    output logic [14:0]      bus_rdata,
    output logic             irq
);
    irq_vec_t set_vec, clr_vec, stat_q, enab_q;

    can_irq_setgen #(.CNT_W(CNT_W), .NERR(5)) u_setgen (
        .arb_lost_p(arb_lost_p), .tx_done_p(tx_done_p), .rx_done_p(rx_done_p),
        .rx_ovf_p(rx_ovf_p), .bus_off_p(bus_off_p), .sleep_in_p(sleep_in_p),
        .sleep_out_p(sleep_out_p), .err_src(err_src), .tx_fifo_full(tx_fifo_full),
        .tx_hp_full(tx_hp_full), .tx_fifo_empty(tx_fifo_empty), .rx_pop(rx_pop),
        .rx_count(rx_count), .rx_wmark(rx_wmark), .tx_free(tx_free),
        .tx_wmark(tx_wmark), .set_vec(set_vec)
    );

    can_irq_stat u_stat (
        .clk(clk), .rst(rst), .core_en(core_en),
        .set_vec(set_vec), .clr_vec(clr_vec), .stat_q(stat_q)
    );

    can_irq_regs u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_q(stat_q),
        .enab_q(enab_q), .clr_vec(clr_vec), .bus_rdata(bus_rdata)
    );

    assign irq = |(stat_q & enab_q);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && enab_q == '0 && !irq));

    // R5
    underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_count == '0 && core_en) |=> stat_q[B_UNF]);
endmodule

// File: tb/can_irq_status_tb.sv
module can_irq_status_tb;
    localparam int CW = 7;

    logic clk = 0, rst = 1, core_en = 1;
    logic arb_lost_p = 0, tx_done_p = 0, rx_done_p = 0, rx_ovf_p = 0;
    logic bus_off_p = 0, sleep_in_p = 0, sleep_out_p = 0;
    logic [4:0] err_src = '0;
    logic tx_fifo_full = 0, tx_hp_full = 0, tx_fifo_empty = 0, rx_pop = 0;
    logic [CW-1:0] rx_count = '0, rx_wmark = '1, tx_free = '0, tx_wmark = '1;
    logic bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = 2'd0;
    logic [14:0] bus_wdata = '0;
    logic [14:0] bus_rdata;
    logic irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    can_irq_status #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .core_en(core_en), .arb_lost_p(arb_lost_p),
        .tx_done_p(tx_done_p), .rx_done_p(rx_done_p), .rx_ovf_p(rx_ovf_p),
        .bus_off_p(bus_off_p), .sleep_in_p(sleep_in_p), .sleep_out_p(sleep_out_p),
        .err_src(err_src), .tx_fifo_full(tx_fifo_full), .tx_hp_full(tx_hp_full),
        .tx_fifo_empty(tx_fifo_empty), .rx_pop(rx_pop), .rx_count(rx_count),
        .rx_wmark(rx_wmark), .tx_free(tx_free), .tx_wmark(tx_wmark),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: returns on the falling edge after the next rising edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [14:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [14:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic clear_all();
        reg_wr(2'd2, 15'h7fff);
    endtask

    task automatic t_reset();
        logic [14:0] v;
        reg_rd(2'd0, v); check("R1 status", v, '0);
        reg_rd(2'd1, v); check("R1 enable", v, '0);
        check("R1 irq", {14'd0, irq}, '0);
    endtask

    task automatic t_events();
        logic [14:0] v;
        clear_all();
        arb_lost_p = 1; tx_done_p = 1; rx_done_p = 1; rx_ovf_p = 1;
        tick();
        arb_lost_p = 0; tx_done_p = 0; rx_done_p = 0; rx_ovf_p = 0;
        bus_off_p = 1; sleep_in_p = 1; sleep_out_p = 1;
        tx_fifo_full = 1; tx_hp_full = 1; tx_fifo_empty = 1;
        tick();
        bus_off_p = 0; sleep_in_p = 0; sleep_out_p = 0;
        tx_fifo_full = 0; tx_hp_full = 0; tx_fifo_empty = 0;
        tick(); tick();
        reg_rd(2'd0, v);
        check("R3 R2 event bit map sticky", v, 15'h4e5f);
        clear_all();
        rx_count = 7'd1;
        tick();
        rx_count = 7'd0;
        tick();
        reg_rd(2'd0, v);
        check("R3 rx not empty bit 7", v, 15'h0080);
    endtask

    task automatic t_error();
        logic [14:0] v;
        for (int k = 0; k < 5; k++) begin
            clear_all();
            err_src = 5'(1 << k);
            tick();
            err_src = '0;
            tick();
            reg_rd(2'd0, v);
            check($sformatf("R4 error source %0d", k), v, 15'h0100);
        end
    endtask

    task automatic t_underflow();
        logic [14:0] v;
        clear_all();
        rx_count = 7'd3; rx_pop = 1;
        tick();
        rx_pop = 0; rx_count = 7'd0;
        clear_all();
        reg_rd(2'd0, v);
        check("R5 pop with data no underflow", v, '0);
        rx_pop = 1;
        tick();
        rx_pop = 0;
        reg_rd(2'd0, v);
        check("R5 pop on empty", v, 15'h0020);
    endtask

    task automatic t_wmark();
        logic [14:0] v;
        clear_all();
        rx_wmark = 7'd4; rx_count = 7'd4; tx_wmark = 7'd9; tx_free = 7'd9;
        tick();
        rx_count = 7'd0; tx_free = 7'd0;
        clear_all();
        reg_rd(2'd0, v);
        check("R6 equal watermark no set", v, '0);
        rx_count = 7'd5;
        tick();
        rx_count = 7'd0;
        clear_all();
        rx_count = 7'd5; tx_free = 7'd10;
        tick();
        rx_count = 7'd0; tx_free = 7'd0;
        rx_wmark = '1; tx_wmark = '1;
        reg_rd(2'd0, v);
        check("R6 above watermarks", v, 15'h3080);
    endtask

    task automatic t_clear();
        logic [14:0] v;
        clear_all();
        arb_lost_p = 1; tx_done_p = 1; bus_off_p = 1;
        tick();
        arb_lost_p = 0; tx_done_p = 0; bus_off_p = 0;
        reg_wr(2'd2, 15'h0002);
        reg_rd(2'd0, v);
        check("R7 clear one bit", v, 15'h0201);
        reg_wr(2'd2, 15'h0000);
        reg_rd(2'd0, v);
        check("R7 zero write no effect", v, 15'h0201);
        reg_rd(2'd2, v);
        check("R7 clear reads zero", v, '0);
    endtask

    task automatic t_setwins();
        logic [14:0] v;
        clear_all();
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 15'h0011;
        arb_lost_p = 1; rx_done_p = 1;
        tick();
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        arb_lost_p = 0; rx_done_p = 0;
        reg_rd(2'd0, v);
        check("R8 set beats clear", v, 15'h0011);
    endtask

    task automatic t_core_en();
        logic [14:0] v;
        clear_all();
        arb_lost_p = 1; tx_done_p = 1; rx_done_p = 1; rx_ovf_p = 1; err_src = 5'h10;
        bus_off_p = 1; sleep_in_p = 1; sleep_out_p = 1;
        tx_fifo_full = 1; tx_hp_full = 1; tx_fifo_empty = 1; rx_pop = 1;
        rx_count = 7'd0; tx_free = 7'd5; tx_wmark = 7'd2;
        tick();
        arb_lost_p = 0; tx_done_p = 0; rx_done_p = 0; rx_ovf_p = 0; err_src = '0;
        bus_off_p = 0; sleep_in_p = 0; sleep_out_p = 0;
        tx_fifo_full = 0; tx_hp_full = 0; tx_fifo_empty = 0; rx_pop = 0;
        tx_free = 7'd0; tx_wmark = '1;
        rx_count = 7'd2;
        tick();
        rx_count = 7'd0;
        reg_rd(2'd0, v);
        check("R9 all set before disable", v, 15'h6fff);
        core_en = 0;
        tick();
        reg_rd(2'd0, v);
        check("R9 disable keeps level bits", v, 15'h60ac);
        arb_lost_p = 1;
        tick();
        arb_lost_p = 0;
        reg_rd(2'd0, v);
        check("R9 event held clear while disabled", v, 15'h60ac);
        core_en = 1;
        tick();
    endtask

    task automatic t_irq();
        logic [14:0] v;
        clear_all();
        reg_wr(2'd1, 15'h0200);
        reg_rd(2'd1, v);
        check("R10 enable readback", v, 15'h0200);
        check("R10 irq low no status", {14'd0, irq}, '0);
        arb_lost_p = 1;
        tick();
        arb_lost_p = 0;
        check("R10 irq low masked bit", {14'd0, irq}, '0);
        bus_off_p = 1;
        tick();
        bus_off_p = 0;
        check("R10 irq high enabled bit", {14'd0, irq}, 15'd1);
        reg_wr(2'd2, 15'h0200);
        check("R10 irq low after clear", {14'd0, irq}, '0);
    endtask

    task automatic t_stat_wr();
        logic [14:0] v;
        clear_all();
        reg_wr(2'd1, 15'h0005);
        tx_done_p = 1;
        tick();
        tx_done_p = 0;
        reg_wr(2'd0, 15'h7ffd);
        reg_rd(2'd0, v);
        check("R11 status write ignored", v, 15'h0002);
        reg_rd(2'd1, v);
        check("R11 enable unchanged", v, 15'h0005);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_events();
        t_error();
        t_underflow();
        t_wmark();
        t_clear();
        t_setwins();
        t_core_en();
        t_irq();
        t_stat_wr();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule